// File: doc/BRIEF.md
# Next-Fit Slot Allocator with Rollover Cache Flush

This block hands out and takes back entries of a translation table. An occupancy bitmap records which slots are in use. An allocation does not restart at slot zero. Its search starts at the position just after the most recent grant and walks upward through the bitmap, examining `SCAN_W` slots per clock. The result is either a grant with the slot index or a failure when no free slot exists.

Releasing a slot only clears its occupancy bit. Any cached translation for that slot may stay live in the translation cache until the slot could be handed out again. That can only happen after the search position has rolled over from the top of the table back to slot zero. At that point the block asks for a flush of the whole cache with a single-cycle request. It then holds the pending grant until the cache side acknowledges. Stale translations are therefore gone before any slot is reused, and frees cost nothing on the cache side.

A requester raises `alloc_req_i` and holds it until `alloc_gnt_o` or `alloc_fail_o` pulses, then lowers it in that same cycle. Releases may arrive in any cycle, including the cycle an allocation is requested.

Top module: `slot_alloc_nextfit`

## Requirements
- R1: After reset every slot is free, all output pulses are low, and the search position is slot 0, so the first allocation is granted slot 0.
- R2: A grant is a one-cycle `alloc_gnt_o` pulse with the slot index on `alloc_idx_o` (below `N_SLOTS`). The granted slot becomes occupied and is not granted again until it is released.
- R3: Allocation is next-fit. The search starts at the slot following the last granted slot, so a released slot below that position is not reused before the search rolls over.
- R4: Releasing an occupied slot clears its occupancy, raises no error and never requests a cache flush.
- R5: When the search moves past the top slot back to slot 0, `flush_req_o` pulses for exactly one cycle. No grant is issued until `flush_ack_i` is seen while waiting, and an acknowledge that arrives with no flush outstanding has no effect.
- R6: If the search covers every slot once without finding a free one, `alloc_fail_o` pulses for one cycle instead of a grant, and the bitmap and search position are left unchanged.
- R7: Releasing a slot that is already free pulses `free_err_o` one cycle later and leaves the bitmap unchanged.
- R8: An allocation and a release in the same cycle are both accepted. The release is applied first, so the slot it frees can be granted by that same search window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request, held until a response pulse |
| alloc_gnt_o | output | 1 | One-cycle grant pulse |
| alloc_fail_o | output | 1 | One-cycle pulse: no free slot found |
| alloc_idx_o | output | $clog2(N_SLOTS) | Granted slot index, valid with alloc_gnt_o |
| free_vld_i | input | 1 | Release strobe |
| free_idx_i | input | $clog2(N_SLOTS) | Slot index to release |
| free_err_o | output | 1 | One-cycle pulse: released slot was already free |
| flush_req_o | output | 1 | One-cycle request to flush the whole translation cache |
| flush_ack_i | input | 1 | Flush completion acknowledge |

## Verification
The allocator is driven by a sequential fill that never rolls over. It then gets a release below the search position followed by an allocation, which separates next-fit from first-fit because the freed low slot must not be returned. A fill to the top that then rolls over shows whether the flush is requested exactly once and whether the grant waits for a delayed acknowledge. Allocations against a completely full table separate failure from a spurious grant. A release issued in the same cycle as a request tells a design that applies the release first from one that misses the slot, because the second kind needs a rollover flush to reach it. Double releases and stray acknowledges check that neither changes the state that later grants reveal.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } alloc_st_e;
endpackage

// File: rtl/slot_bitmap.sv
module slot_bitmap #(
  parameter int N_SLOTS = 32,
  localparam int IW = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               free_vld_i,
  input  logic [IW-1:0]      free_idx_i,
  input  logic               set_vld_i,
  input  logic [IW-1:0]      set_idx_i,
  output logic [N_SLOTS-1:0] map_o,
  output logic [N_SLOTS-1:0] eff_map_o,
  output logic               free_err_o
);
  logic [N_SLOTS-1:0] map_q, map_d;
  logic               free_ok, free_bad, err_q;
  logic               in_rng;

  assign in_rng   = {1'b0, free_idx_i} < (IW+1)'(N_SLOTS);
  assign free_ok  = free_vld_i && in_rng && map_q[free_idx_i];
  assign free_bad = free_vld_i && !free_ok;

  // release is applied before the search sees the map
  always_comb begin
    eff_map_o = map_q;
    if (free_ok) eff_map_o[free_idx_i] = 1'b0;
    map_d = eff_map_o;
    if (set_vld_i) map_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      err_q <= 1'b0;
    end else begin
      map_q <= map_d;
      err_q <= free_bad;
    end
  end

  assign map_o      = map_q;
  assign free_err_o = err_q;

  assert_bad_free_keeps_map_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_bad && !set_vld_i) |=> $stable(map_q));

  assert_free_clears_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_ok && !(set_vld_i && set_idx_i == free_idx_i)) |=> !map_q[$past(free_idx_i)]);
endmodule

// File: rtl/slot_window_scan.sv
module slot_window_scan #(
  parameter int N_SLOTS = 32,
  parameter int SCAN_W  = 8,
  localparam int IW = $clog2(N_SLOTS),
  localparam int CW = $clog2(N_SLOTS + 1),
  localparam int OW = (SCAN_W > 1) ? $clog2(SCAN_W) : 1
) (
  input  logic [N_SLOTS-1:0] map_i,
  input  logic [CW-1:0]      base_i,
  output logic               found_o,
  output logic [OW-1:0]      offs_o,
  output logic [CW-1:0]      len_o,
  output logic               top_o
);
  logic [SCAN_W-1:0] win_free;
  logic [CW-1:0]     rem;

  for (genvar i = 0; i < SCAN_W; i++) begin : g_win
    logic [CW:0] pos_w;
    logic        in_rng;
    assign pos_w  = {1'b0, base_i} + (CW+1)'(i);
    assign in_rng = pos_w < (CW+1)'(N_SLOTS);
    assign win_free[i] = in_rng && !map_i[pos_w[IW-1:0]];
  end

  always_comb begin
    found_o = 1'b0;
    offs_o  = '0;
    for (int i = SCAN_W - 1; i >= 0; i--) begin
      if (win_free[i]) begin
        found_o = 1'b1;
        offs_o  = OW'(i);
      end
    end
  end

  assign rem   = CW'(N_SLOTS) - base_i;
  assign len_o = (rem < CW'(SCAN_W)) ? rem : CW'(SCAN_W);
  assign top_o = ({1'b0, base_i} + (CW+1)'(SCAN_W)) >= (CW+1)'(N_SLOTS);
endmodule

// File: rtl/slot_alloc_nextfit.sv
module slot_alloc_nextfit
  import slot_alloc_pkg::*;
#(
  parameter int N_SLOTS = 32,
  parameter int SCAN_W  = 8,
  localparam int IW = $clog2(N_SLOTS),
  localparam int CW = $clog2(N_SLOTS + 1),
  localparam int OW = (SCAN_W > 1) ? $clog2(SCAN_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_req_i,
  output logic          alloc_gnt_o,
  output logic          alloc_fail_o,
  output logic [IW-1:0] alloc_idx_o,
  input  logic          free_vld_i,
  input  logic [IW-1:0] free_idx_i,
  output logic          free_err_o,
  output logic          flush_req_o,
  input  logic          flush_ack_i
);
  alloc_st_e          st_q;
  logic [CW-1:0]      pos_q, cursor_q, base, slot;
  logic [CW:0]        cnt_q, cnt_b, cnt_nx;
  logic               gnt_q, fail_q, flush_q;
  logic [IW-1:0]      idx_q;
  logic [N_SLOTS-1:0] map, eff_map;
  logic               found, top, scan_en, hit, miss_all, wrap;
  logic [OW-1:0]      offs;
  logic [CW-1:0]      len;

  slot_bitmap #(.N_SLOTS(N_SLOTS)) i_bitmap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .free_vld_i (free_vld_i),
    .free_idx_i (free_idx_i),
    .set_vld_i  (hit),
    .set_idx_i  (slot[IW-1:0]),
    .map_o      (map),
    .eff_map_o  (eff_map),
    .free_err_o (free_err_o)
  );

  slot_window_scan #(.N_SLOTS(N_SLOTS), .SCAN_W(SCAN_W)) i_scan (
    .map_i   (eff_map),
    .base_i  (base),
    .found_o (found),
    .offs_o  (offs),
    .len_o   (len),
    .top_o   (top)
  );

  // first window is examined in the request cycle itself
  assign base     = (st_q == ST_IDLE) ? cursor_q : pos_q;
  assign cnt_b    = (st_q == ST_IDLE) ? '0 : cnt_q;
  assign scan_en  = ((st_q == ST_IDLE) && alloc_req_i) || (st_q == ST_SCAN);
  assign cnt_nx   = cnt_b + (CW+1)'(len);
  assign slot     = base + CW'(offs);
  assign hit      = scan_en && found;
  assign miss_all = scan_en && !found && (cnt_nx >= (CW+1)'(N_SLOTS));
  assign wrap     = scan_en && !found && !miss_all && top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pos_q    <= '0;
      cnt_q    <= '0;
      cursor_q <= '0;
      gnt_q    <= 1'b0;
      fail_q   <= 1'b0;
      flush_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      gnt_q   <= 1'b0;
      fail_q  <= 1'b0;
      flush_q <= 1'b0;
      if (hit) begin
        gnt_q    <= 1'b1;
        idx_q    <= slot[IW-1:0];
        cursor_q <= slot + CW'(1);
        st_q     <= ST_IDLE;
      end else if (miss_all) begin
        fail_q <= 1'b1;
        st_q   <= ST_IDLE;
      end else if (wrap) begin
        flush_q <= 1'b1;
        pos_q   <= '0;
        cnt_q   <= cnt_nx;
        st_q    <= ST_WAIT;
      end else if (scan_en) begin
        pos_q <= base + CW'(SCAN_W);
        cnt_q <= cnt_nx;
        st_q  <= ST_SCAN;
      end else if ((st_q == ST_WAIT) && flush_ack_i) begin
        st_q <= ST_SCAN;
      end
    end
  end

  assign alloc_gnt_o  = gnt_q;
  assign alloc_fail_o = fail_q;
  assign alloc_idx_o  = idx_q;
  assign flush_req_o  = flush_q;

  assert_resp_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_gnt_o && alloc_fail_o));

  assert_flush_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |=> !flush_req_o);

  assert_grant_held_for_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && !flush_ack_i) |=> !alloc_gnt_o);

  assert_grant_marks_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> map[alloc_idx_o]);

  assert_grant_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> ({1'b0, alloc_idx_o} < (IW+1)'(N_SLOTS)));
endmodule

// File: tb/test_slot_alloc_nextfit.sv
`timescale 1ns/1ps
module test_slot_alloc_nextfit;
  localparam int N  = 32;
  localparam int SW = 8;
  localparam int IW = $clog2(N);

  typedef struct {
    bit fail;
    int slot;
    int flush;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic          alloc_gnt, alloc_fail;
  logic [IW-1:0] alloc_idx;
  logic          free_vld = 1'b0;
  logic [IW-1:0] free_idx = '0;
  logic          free_err, flush_req;
  logic          resp_ack = 1'b0, spur_ack = 1'b0;
  logic          flush_ack;

  assign flush_ack = resp_ack | spur_ack;

  int n_chk = 0, n_fail = 0;
  int resp_cnt = 0, flush_cnt = 0, flush_mark = 0;
  bit waiting_ack = 1'b0;
  bit ref_map [N];
  int ref_cur = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  slot_alloc_nextfit #(.N_SLOTS(N), .SCAN_W(SW)) i_slot_alloc_nextfit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .alloc_req_i  (alloc_req),
    .alloc_gnt_o  (alloc_gnt),
    .alloc_fail_o (alloc_fail),
    .alloc_idx_o  (alloc_idx),
    .free_vld_i   (free_vld),
    .free_idx_i   (free_idx),
    .free_err_o   (free_err),
    .flush_req_o  (flush_req),
    .flush_ack_i  (flush_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic exp_t model_alloc();
    exp_t e;
    e.fail = 1'b1; e.slot = -1; e.flush = 0;
    for (int k = ref_cur; k < N; k++)
      if (e.fail && !ref_map[k]) begin e.fail = 1'b0; e.slot = k; end
    if (e.fail && ref_cur != 0) begin
      e.flush = 1;
      for (int k = 0; k < ref_cur; k++)
        if (e.fail && !ref_map[k]) begin e.fail = 1'b0; e.slot = k; end
    end
    if (!e.fail) begin
      ref_map[e.slot] = 1'b1;
      ref_cur = e.slot + 1;
    end
    return e;
  endfunction

  // flush responder: acknowledges three cycles after each request
  initial begin
    forever begin
      @(posedge clk); #1;
      if (flush_req) begin
        flush_cnt++;
        waiting_ack = 1'b1;
        repeat (3) @(negedge clk);
        resp_ack = 1'b1;
        @(posedge clk); #1;
        waiting_ack = 1'b0;
        @(negedge clk);
        resp_ack = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (alloc_gnt && waiting_ack)
          chk(1'b0, "R5 grant before flush ack", 1, 0);
        if (alloc_gnt && alloc_fail)
          chk(1'b0, "R6 grant and fail together", 1, 0);
        if (alloc_gnt || alloc_fail) begin
          exp_t e;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected response", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(alloc_fail == e.fail, "R6 fail vs grant", int'(alloc_fail), int'(e.fail));
            if (!e.fail)
              chk(int'(alloc_idx) == e.slot, "R3 granted slot", int'(alloc_idx), e.slot);
            chk((flush_cnt - flush_mark) == e.flush, "R5 flush count", flush_cnt - flush_mark, e.flush);
          end
          flush_mark = flush_cnt;
          resp_cnt++;
        end
      end
    end
  end

  task automatic do_alloc(input bit fe, input int fidx);
    exp_t e;
    int start, guard;
    if (fe) ref_map[fidx] = 1'b0;
    e = model_alloc();
    exp_q.push_back(e);
    start = resp_cnt;
    @(negedge clk);
    alloc_req = 1'b1;
    free_vld  = fe;
    free_idx  = IW'(fidx);
    @(negedge clk);
    free_vld = 1'b0;
    guard = 0;
    while (resp_cnt == start && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    alloc_req = 1'b0;
    if (resp_cnt == start) chk(1'b0, "R2 no response", 0, 1);
    @(negedge clk);
    chk(!alloc_gnt && !alloc_fail, "R2 response is one cycle", int'(alloc_gnt | alloc_fail), 0);
  endtask

  task automatic do_free(input int idx, input bit exp_err);
    int f0;
    f0 = flush_cnt;
    if (!exp_err) ref_map[idx] = 1'b0;
    @(negedge clk);
    free_vld = 1'b1;
    free_idx = IW'(idx);
    @(negedge clk);
    free_vld = 1'b0;
    chk(free_err == exp_err, exp_err ? "R7 double free error" : "R4 free no error",
        int'(free_err), int'(exp_err));
    repeat (2) @(negedge clk);
    chk(flush_cnt == f0, "R4 free requests no flush", flush_cnt - f0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) ref_map[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(!alloc_gnt && !alloc_fail && !flush_req && !free_err, "R1 reset outputs",
        int'({alloc_gnt, alloc_fail, flush_req, free_err}), 0);
    // R1, R2: first grants start at slot 0
    for (int k = 0; k < 5; k++) do_alloc(1'b0, 0);
    // R4: release below cursor, R3: not reused yet
    do_free(1, 1'b0);
    do_alloc(1'b0, 0);
    // R7: release of an already free slot
    do_free(1, 1'b1);
    // fill to the top: slots 6..31
    for (int k = 6; k < N; k++) do_alloc(1'b0, 0);
    // R5: stray acknowledge with nothing outstanding is ignored
    @(negedge clk); spur_ack = 1'b1;
    @(negedge clk); spur_ack = 1'b0;
    // R5: rollover flush, slot 1 granted after ack
    do_alloc(1'b0, 0);
    // R6: table full, fail after rollover
    do_alloc(1'b0, 0);
    do_alloc(1'b0, 0);
    // R8: simultaneous release and request
    do_alloc(1'b1, 3);
    // R3: next-fit finds a high slot without rollover
    do_free(31, 1'b0);
    do_free(0, 1'b0);
    do_alloc(1'b0, 0);
    // R5: rollover again, grant slot 0
    do_alloc(1'b0, 0);
    // R6: full again from cursor at slot 1
    do_alloc(1'b0, 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected responses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule